// File: doc/BRIEF.md
# Keyed-Hash Engine Control Register Guard

This block holds the software-visible control state of a keyed-hash accelerator. It sits between a simple single-cycle register port and the hash core. It stores the four configuration bits and the eight 32-bit key words, and it converts command writes into one-cycle start and process pulses. It captures the digest that the core produces and presents it one word at a time, with optional byte reversal inside each word. It also keeps three event interrupts: done, FIFO empty and error.

While the core reports that it is busy, the block protects its state. A configuration write in that window is dropped without any notice. A key write in that window is refused, and the block records error code 1 and raises the error interrupt. A write to the wipe register overwrites every key word and every digest word with the written value. Reads are combinational on the current address.

Top module: `hash_reg_guard`

## Requirements
- R1: Word addresses are: 0 interrupt status, 1 interrupt enable, 2 interrupt test, 3 configuration, 4 command, 5 error code, 6 wipe, 8..15 key words 0..7, 16..23 digest words 0..7. An idle configuration write stores wdata[3:0]: bit 0 keyed enable, bit 1 hash enable, bit 2 input byte swap, bit 3 digest swap. The value reads back at address 3 and drives the matching output ports.
- R2: A configuration write while core_busy_i is 1 is dropped, and the previous value is kept.
- R3: An idle key write stores the word. key_o equals {key0, key1, ..., key7}, so key word 0 occupies bits 255:224. Key addresses read as 0.
- R4: A key write while core_busy_i is 1 leaves the key unchanged, sets interrupt status bit 2 and sets the error code to 1.
- R5: The error code holds its value until software clears status bit 2. After that it reads 0, which means no error.
- R6: Writing 1 to command bit 0 gives exactly one cycle of start_o. Writing 1 to bit 1 gives one cycle of process_o. The command address reads 0.
- R7: Interrupt status bits are done (bit 0), FIFO empty (bit 1) and error (bit 2). Writing 1 to a status bit clears it, and writing 1 to a test bit sets the matching status bit. Each irq output is its status bit AND its enable bit.
- R8: A hardware event sets its status bit even in the same cycle that software writes 1 to clear it.
- R9: A core_done_i pulse with hash enable set captures core_digest_i. Digest word 0 reads bits 255:224, and core_done_i sets status bit 0.
- R10: With digest swap set, each digest word reads byte-reversed, and the word order stays the same.
- R11: While hash enable is 0, the stored digest is cleared to zero one cycle later.
- R12: A wipe write sets every key word and every digest word to the written value.
- R13: After reset, configuration, key, digest, interrupt status, enable, error code and pulses are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 5 | Register word address |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for reg_addr_i |
| core_busy_i | input | 1 | Core is computing |
| core_done_i | input | 1 | Core finished, digest valid |
| fifo_empty_i | input | 1 | Message FIFO became empty |
| core_digest_i | input | 256 | Digest from core, word 0 in MSBs |
| keyed_en_o | output | 1 | Keyed mode enable |
| hash_en_o | output | 1 | Hash enable |
| in_swap_o | output | 1 | Input byte swap |
| dig_swap_o | output | 1 | Digest byte swap |
| key_o | output | 256 | Key to core, word 0 in MSBs |
| start_o | output | 1 | One-cycle start pulse |
| process_o | output | 1 | One-cycle process pulse |
| irq_done_o | output | 1 | Done interrupt |
| irq_empty_o | output | 1 | FIFO empty interrupt |
| irq_err_o | output | 1 | Error interrupt |

## Verification
A busy gate that leaks would show up on the configuration ports or on key_o one cycle after the refused write. A missed error shows up as a zero error code at that same read. A sticky or lost interrupt bit shows up on the status read and the irq pins in the cycle after the write or event. A wrong digest path shows up as a byte-order or word-order mismatch on the first digest read after capture. A stale digest shows up one cycle after hash enable drops.

// File: rtl/hrg_pkg.sv
package hrg_pkg;
  localparam int unsigned AW = 5;
  localparam int unsigned DW = 32;
  localparam int unsigned NW = 8;
  localparam int unsigned NIRQ = 3;

  localparam logic [AW-1:0] A_ISTATE = 5'd0;
  localparam logic [AW-1:0] A_IEN    = 5'd1;
  localparam logic [AW-1:0] A_ITEST  = 5'd2;
  localparam logic [AW-1:0] A_CFG    = 5'd3;
  localparam logic [AW-1:0] A_CMD    = 5'd4;
  localparam logic [AW-1:0] A_ERR    = 5'd5;
  localparam logic [AW-1:0] A_WIPE   = 5'd6;
  localparam logic [AW-1:0] A_KEY0   = 5'd8;
  localparam logic [AW-1:0] A_DIG0   = 5'd16;

  typedef enum logic [7:0] {
    ERR_NONE     = 8'd0,
    ERR_KEY_BUSY = 8'd1
  } err_e;

  typedef struct packed {
    logic dig_swap;
    logic in_swap;
    logic hash_en;
    logic keyed_en;
  } cfg_t;
endpackage

// File: rtl/hrg_cfg_key.sv
module hrg_cfg_key
  import hrg_pkg::*;
#(
  parameter int unsigned N_WORDS = NW,
  parameter int unsigned W = DW
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 we_i,
  input  logic [AW-1:0]        addr_i,
  input  logic [W-1:0]         wdata_i,
  input  logic                 busy_i,
  input  logic                 wipe_i,
  input  logic                 err_clr_i,
  output cfg_t                 cfg_o,
  output logic [N_WORDS*W-1:0] key_o,
  output logic                 err_evt_o,
  output err_e                 err_code_o
);
  localparam logic [AW-1:0] KEY_END = AW'(A_KEY0 + N_WORDS);

  logic          key_hit;
  logic [AW-1:0] key_idx;
  logic [W-1:0]  key_q [N_WORDS];

  assign key_hit   = we_i && (addr_i >= A_KEY0) && (addr_i < KEY_END);
  assign key_idx   = addr_i - A_KEY0;
  assign err_evt_o = key_hit && busy_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cfg_o <= '0;
    else if (we_i && addr_i == A_CFG && !busy_i) cfg_o <= cfg_t'(wdata_i[3:0]);
  end

  for (genvar i = 0; i < N_WORDS; i++) begin : g_key
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) key_q[i] <= '0;
      else if (wipe_i) key_q[i] <= wdata_i;
      else if (key_hit && !busy_i && key_idx == AW'(i)) key_q[i] <= wdata_i;
    end
    assign key_o[(N_WORDS-1-i)*W +: W] = key_q[i];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) err_code_o <= ERR_NONE;
    else if (err_evt_o) err_code_o <= ERR_KEY_BUSY;
    else if (err_clr_i) err_code_o <= ERR_NONE;
  end

  assert_cfg_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && we_i && addr_i == A_CFG) |=> $stable(cfg_o));
  assert_key_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && key_hit && !wipe_i) |=> $stable(key_o));
  assert_err_code_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && key_hit) |=> err_code_o == ERR_KEY_BUSY);
  assert_err_clear_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_clr_i && !err_evt_o) |=> err_code_o == ERR_NONE);
endmodule

// File: rtl/hrg_intr.sv
module hrg_intr
  import hrg_pkg::*;
#(
  parameter int unsigned N = NIRQ
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [N-1:0]  wbits_i,
  input  logic [N-1:0]  hw_evt_i,
  output logic [N-1:0]  state_o,
  output logic [N-1:0]  en_o,
  output logic [N-1:0]  irq_o
);
  logic [N-1:0] clr, set;

  assign clr = (we_i && addr_i == A_ISTATE) ? wbits_i : '0;
  assign set = hw_evt_i | ((we_i && addr_i == A_ITEST) ? wbits_i : '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_o <= '0;
      en_o    <= '0;
    end else begin
      state_o <= (state_o & ~clr) | set;  // set wins over clear
      if (we_i && addr_i == A_IEN) en_o <= wbits_i;
    end
  end

  assign irq_o = state_o & en_o;

  for (genvar i = 0; i < N; i++) begin : g_chk
    assert_evt_wins_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      hw_evt_i[i] |=> state_o[i]);
    assert_w1c_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr[i] && !set[i]) |=> !state_o[i]);
  end
endmodule

// File: rtl/hrg_digest.sv
module hrg_digest
  import hrg_pkg::*;
#(
  parameter int unsigned N_WORDS = NW,
  parameter int unsigned W = DW,
  localparam int unsigned IW = $clog2(N_WORDS)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 hash_en_i,
  input  logic                 swap_i,
  input  logic                 capture_i,
  input  logic [N_WORDS*W-1:0] core_digest_i,
  input  logic                 wipe_i,
  input  logic [W-1:0]         wipe_data_i,
  input  logic [IW-1:0]        rd_idx_i,
  output logic [W-1:0]         rd_word_o
);
  localparam int unsigned NB = W / 8;

  logic [W-1:0] dig_q [N_WORDS];
  logic [W-1:0] sel, rev;

  for (genvar i = 0; i < N_WORDS; i++) begin : g_word
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) dig_q[i] <= '0;
      else if (!hash_en_i) dig_q[i] <= '0;
      else if (wipe_i) dig_q[i] <= wipe_data_i;
      else if (capture_i) dig_q[i] <= core_digest_i[(N_WORDS-1-i)*W +: W];
    end
  end

  assign sel = dig_q[rd_idx_i];
  for (genvar b = 0; b < NB; b++) begin : g_rev
    assign rev[b*8 +: 8] = sel[(NB-1-b)*8 +: 8];
  end
  assign rd_word_o = swap_i ? rev : sel;

  assert_clear_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hash_en_i |=> (dig_q[0] == '0 && dig_q[N_WORDS-1] == '0));
  assert_capture_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hash_en_i && capture_i && !wipe_i) |=> dig_q[0] == $past(core_digest_i[N_WORDS*W-1 -: W]));
endmodule

// File: rtl/hash_reg_guard.sv
module hash_reg_guard
  import hrg_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            reg_we_i,
  input  logic [AW-1:0]   reg_addr_i,
  input  logic [DW-1:0]   reg_wdata_i,
  output logic [DW-1:0]   reg_rdata_o,
  input  logic            core_busy_i,
  input  logic            core_done_i,
  input  logic            fifo_empty_i,
  input  logic [NW*DW-1:0] core_digest_i,
  output logic            keyed_en_o,
  output logic            hash_en_o,
  output logic            in_swap_o,
  output logic            dig_swap_o,
  output logic [NW*DW-1:0] key_o,
  output logic            start_o,
  output logic            process_o,
  output logic            irq_done_o,
  output logic            irq_empty_o,
  output logic            irq_err_o
);
  localparam int unsigned IW = $clog2(NW);
  localparam logic [AW-1:0] DIG_END = AW'(A_DIG0 + NW);

  cfg_t            cfg;
  err_e            err_code;
  logic            err_evt, err_clr, wipe;
  logic [NIRQ-1:0] istate, ien, irq;
  logic [DW-1:0]   dig_word;
  logic            cmd_wr;

  assign wipe    = reg_we_i && reg_addr_i == A_WIPE;
  assign err_clr = reg_we_i && reg_addr_i == A_ISTATE && reg_wdata_i[2];
  assign cmd_wr  = reg_we_i && reg_addr_i == A_CMD;

  hrg_cfg_key #(.N_WORDS(NW), .W(DW)) u_cfg_key (
    .clk_i, .rst_ni,
    .we_i      (reg_we_i),
    .addr_i    (reg_addr_i),
    .wdata_i   (reg_wdata_i),
    .busy_i    (core_busy_i),
    .wipe_i    (wipe),
    .err_clr_i (err_clr),
    .cfg_o     (cfg),
    .key_o     (key_o),
    .err_evt_o (err_evt),
    .err_code_o(err_code)
  );

  hrg_intr #(.N(NIRQ)) u_intr (
    .clk_i, .rst_ni,
    .we_i     (reg_we_i),
    .addr_i   (reg_addr_i),
    .wbits_i  (reg_wdata_i[NIRQ-1:0]),
    .hw_evt_i ({err_evt, fifo_empty_i, core_done_i}),
    .state_o  (istate),
    .en_o     (ien),
    .irq_o    (irq)
  );

  hrg_digest #(.N_WORDS(NW), .W(DW)) u_digest (
    .clk_i, .rst_ni,
    .hash_en_i    (cfg.hash_en),
    .swap_i       (cfg.dig_swap),
    .capture_i    (core_done_i),
    .core_digest_i(core_digest_i),
    .wipe_i       (wipe),
    .wipe_data_i  (reg_wdata_i),
    .rd_idx_i     (reg_addr_i[IW-1:0]),
    .rd_word_o    (dig_word)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      start_o   <= 1'b0;
      process_o <= 1'b0;
    end else begin
      start_o   <= cmd_wr && reg_wdata_i[0];
      process_o <= cmd_wr && reg_wdata_i[1];
    end
  end

  always_comb begin
    reg_rdata_o = '0;
    if (reg_addr_i >= A_DIG0 && reg_addr_i < DIG_END) reg_rdata_o = dig_word;
    else begin
      case (reg_addr_i)
        A_ISTATE: reg_rdata_o = DW'(istate);
        A_IEN:    reg_rdata_o = DW'(ien);
        A_CFG:    reg_rdata_o = DW'(cfg);
        A_ERR:    reg_rdata_o = DW'(err_code);
        default:  reg_rdata_o = '0;
      endcase
    end
  end

  assign keyed_en_o  = cfg.keyed_en;
  assign hash_en_o   = cfg.hash_en;
  assign in_swap_o   = cfg.in_swap;
  assign dig_swap_o  = cfg.dig_swap;
  assign irq_done_o  = irq[0];
  assign irq_empty_o = irq[1];
  assign irq_err_o   = irq[2];

  assert_start_src_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_wr && reg_wdata_i[0]) |=> start_o);
  assert_err_irq_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_evt |=> (istate[2] && err_code == ERR_KEY_BUSY));
endmodule

// File: tb/hash_reg_guard_bench.sv
module hash_reg_guard_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic we = 1'b0;
  logic [4:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic busy = 1'b0, done = 1'b0, fempty = 1'b0;
  logic [255:0] cdig = '0, key;
  logic keyed_en, hash_en, in_swap, dig_swap, start, process, irq_d, irq_e, irq_x;

  int total = 0, bad = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  hash_reg_guard u_hash_reg_guard (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .core_busy_i(busy),
    .core_done_i(done), .fifo_empty_i(fempty), .core_digest_i(cdig),
    .keyed_en_o(keyed_en), .hash_en_o(hash_en), .in_swap_o(in_swap),
    .dig_swap_o(dig_swap), .key_o(key), .start_o(start), .process_o(process),
    .irq_done_o(irq_d), .irq_empty_o(irq_e), .irq_err_o(irq_x)
  );

  // {busy, wdata[3:0], expected cfg}
  localparam logic [8:0] CFG_VEC [6] = '{
    {1'b0, 4'h5, 4'h5}, {1'b1, 4'hA, 4'h5}, {1'b0, 4'hF, 4'hF},
    {1'b1, 4'h0, 4'hF}, {1'b0, 4'h3, 4'h3}, {1'b0, 4'h2, 4'h2}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    addr = a;
    #0.5;
    d = rdata;
  endtask

  function automatic logic [31:0] bswap(input logic [31:0] v);
    return {v[7:0], v[15:8], v[23:16], v[31:24]};
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R13 reset state
    rd(5'd3, r);  chk("R13 cfg", r, 0);
    rd(5'd0, r);  chk("R13 istate", r, 0);
    rd(5'd5, r);  chk("R13 err", r, 0);
    rd(5'd16, r); chk("R13 digest", r, 0);
    chk("R13 key", 32'(key != '0), 0);
    chk("R13 pulses", {30'd0, start, process}, 0);

    // R1/R2 table
    foreach (CFG_VEC[i]) begin
      busy = CFG_VEC[i][8];
      wr(5'd3, {28'd0, CFG_VEC[i][7:4]});
      busy = 1'b0;
      rd(5'd3, r);
      chk(CFG_VEC[i][8] ? "R2 cfg busy" : "R1 cfg idle", r, {28'd0, CFG_VEC[i][3:0]});
      chk("R1 cfg ports", {28'd0, dig_swap, in_swap, hash_en, keyed_en}, {28'd0, CFG_VEC[i][3:0]});
    end

    // R3 key writes
    for (int i = 0; i < 8; i++) wr(5'(8 + i), 32'hC0DE0000 + 32'(i));
    for (int i = 0; i < 8; i++) chk("R3 key word", key[(7-i)*32 +: 32], 32'hC0DE0000 + 32'(i));
    rd(5'd10, r); chk("R3 key read zero", r, 0);

    // R4 busy key write
    busy = 1'b1;
    wr(5'd10, 32'hDEADBEEF);
    busy = 1'b0;
    chk("R4 key unchanged", key[5*32 +: 32], 32'hC0DE0002);
    rd(5'd0, r); chk("R4 err status", r, 32'h4);
    rd(5'd5, r); chk("R4 err code", r, 1);
    wr(5'd0, 32'h1); // clear other bit only
    rd(5'd5, r); chk("R5 code held", r, 1);
    wr(5'd0, 32'h4);
    rd(5'd5, r); chk("R5 code cleared", r, 0);
    rd(5'd0, r); chk("R5 status cleared", r, 0);

    // R6 command pulses
    @(negedge clk); we = 1'b1; addr = 5'd4; wdata = 32'h1;
    @(negedge clk); we = 1'b0;
    chk("R6 start high", {30'd0, start, process}, 32'h2);
    @(negedge clk);
    chk("R6 start low", {30'd0, start, process}, 0);
    @(negedge clk); we = 1'b1; addr = 5'd4; wdata = 32'h2;
    @(negedge clk); we = 1'b0;
    chk("R6 process high", {30'd0, start, process}, 32'h1);
    rd(5'd4, r); chk("R6 cmd reads 0", r, 0);
    @(negedge clk);
    chk("R6 process low", {30'd0, start, process}, 0);

    // R7 interrupts
    wr(5'd1, 32'h5);
    wr(5'd2, 32'h3);
    rd(5'd0, r); chk("R7 test sets", r, 32'h3);
    chk("R7 irq", {29'd0, irq_x, irq_e, irq_d}, 32'h1);
    wr(5'd0, 32'h1);
    rd(5'd0, r); chk("R7 w1c", r, 32'h2);
    chk("R7 irq after clear", {29'd0, irq_x, irq_e, irq_d}, 0);
    wr(5'd0, 32'h7);

    // R8 event wins, R9 capture (cfg hash_en=1 from table)
    for (int i = 0; i < 8; i++) cdig[(7-i)*32 +: 32] = 32'h01020304 + 32'(i) * 32'h10101010;
    @(negedge clk); we = 1'b1; addr = 5'd0; wdata = 32'h1; done = 1'b1; fempty = 1'b1;
    @(negedge clk); we = 1'b0; done = 1'b0; fempty = 1'b0;
    rd(5'd0, r); chk("R8 event wins", r, 32'h3);
    rd(5'd16, r); chk("R9 digest w0", r, 32'h01020304);
    rd(5'd23, r); chk("R9 digest w7", r, 32'h71727374);

    // R10 swap
    wr(5'd3, 32'hA);
    rd(5'd16, r); chk("R10 swap w0", r, bswap(32'h01020304));
    rd(5'd19, r); chk("R10 swap w3", r, bswap(32'h31323334));

    // R11 clear
    wr(5'd3, 32'h0);
    @(negedge clk);
    wr(5'd3, 32'h2);
    rd(5'd16, r); chk("R11 digest cleared", r, 0);

    // R12 wipe
    wr(5'd6, 32'h5A5AA5A5);
    chk("R12 key w0", key[255:224], 32'h5A5AA5A5);
    chk("R12 key w7", key[31:0], 32'h5A5AA5A5);
    rd(5'd19, r); chk("R12 digest w3", r, 32'h5A5AA5A5);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule